// File: doc/BRIEF.md
# Extended-Mode Control Window with Test FIFO

This block is the upper register window of a parallel port. It sits eight byte addresses wide and is reached through a simple synchronous bus with select, write and read strobes. The window holds an extended control register with a three-bit operating-mode field and a two-bit FIFO occupancy code, a general configuration register, and a small byte FIFO. The FIFO is reachable through offset 0 only while the mode field selects FIFO-test. In every other mode, offset 0 is an ordinary read/write byte.

Software puts the port into FIFO-test mode and pushes bytes by writing offset 0. It pops bytes by reading offset 0 and watches the occupancy code in the control register. Any write to the control register that changes the mode discards whatever the FIFO holds. Read data is combinational from the current state during the read cycle. The pop, like every other state change, takes effect at the clock edge that ends the access.

Top module: `ecpx_window`

## Requirements
- R1: After a synchronous active-low reset, the control register (offset 2) reads 0x01, which is mode 000 (compatible) with occupancy code 01 (empty). Offsets 0 and 1 read 0x00.
- R2: In the control register, bits 7:5 hold the mode and bits 4:2 are plain storage. Bits 1:0 hold the occupancy code: 00 some data, 01 empty, 10 full, and 11 never appears. A write replaces bits 7:2, and the written bits 1:0 are ignored.
- R3: When the mode is not 110 (FIFO test), offset 0 is a plain byte register. Writing or reading it does not touch the FIFO or its occupancy code, and FIFO traffic does not alter it.
- R4: In mode 110, a write at offset 0 pushes the byte. After the push the code is 10 if the FIFO has filled (DEPTH bytes), and 00 otherwise.
- R5: In mode 110, a read at offset 0 returns the oldest byte and pops it. After the pop the code is 01 if nothing remains, and 00 otherwise.
- R6: A push while the code is 10 (and no pop in the same cycle) is dropped, and the stored bytes and code stay as they were.
- R7: A pop while the code is 01 returns 0xFF and leaves the FIFO and the code unchanged.
- R8: A control write whose bits 7:5 differ from the current mode empties the FIFO and sets the code to 01.
- R9: A control write that keeps the same mode leaves the FIFO contents, pointers and code unchanged.
- R10: Offset 1 is a read/write configuration byte. Offsets 3 to 7 read 0xFF, and writes to them have no effect.
- R11: In mode 110, a read and a write at offset 0 in the same cycle pop and push together. When the FIFO is empty, the read returns 0xFF and the push is kept. When it is full, the pop frees the slot the push uses, and the code stays 10.
- R12: Both pointers wrap at DEPTH, so bytes come out in push order across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access select for this window |
| bus_wr | input | 1 | Write strobe, acted on at the clock edge |
| bus_rd | input | 1 | Read strobe; a FIFO pop happens at the clock edge |
| bus_addr | input | 3 | Byte offset inside the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |

## Verification
The push and the pop are the two functions that can share one cycle. A single access that raises both strobes at offset 0 in FIFO-test mode provokes this, once with the FIFO empty and once with it full. In the empty case, the returned byte must be 0xFF and the pushed byte must be the next one popped. In the full case, the returned byte must be the oldest entry, the code must stay full, and the following pops must yield the remaining bytes in push order. The mode-change flush is also driven against a full FIFO, and the bench judges it by the code it reads back and by a pop that returns 0xFF.

// File: rtl/ecpx_pkg.sv
// Package: shared encodings for the extended-mode control window.
// Assumes an 8-byte window; offsets below are decoded by the top module.
package ecpx_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [2:0] {
        MODE_COMPAT    = 3'b000,
        MODE_BYTE      = 3'b001,
        MODE_PP_FIFO   = 3'b010,
        MODE_EXT_FIFO  = 3'b011,
        MODE_ADDR_DATA = 3'b100,
        MODE_RSVD      = 3'b101,
        MODE_FIFO_TEST = 3'b110,
        MODE_CONFIG    = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        FST_SOME  = 2'b00,
        FST_EMPTY = 2'b01,
        FST_FULL  = 2'b10
    } fifo_stat_e;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;

endpackage

// File: rtl/ecpx_fifo.sv
// Module: ecpx_fifo
// Small circular byte FIFO with an explicit occupancy code (some/empty/full).
// Assumes push and pop are already qualified by mode; flush has priority
// over both. A pop while empty yields all ones; a push while full is dropped
// unless a pop in the same cycle frees a slot.
module ecpx_fifo
    import ecpx_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output fifo_stat_e    stat
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW-1:0] wnext, rnext;
    logic          is_empty, is_full;
    logic          pop_ok, push_ok;

    // Advance a pointer, wrapping after the last slot.
    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        if (p == LAST) return '0;
        return p + 1'b1;
    endfunction

    // Qualify requests against the occupancy before this cycle.
    always_comb begin
        is_empty = (stat == FST_EMPTY);
        is_full  = (stat == FST_FULL);
        pop_ok   = pop && !is_empty && !flush;
        push_ok  = push && (!is_full || pop_ok) && !flush;
        wnext    = wrap_inc(wptr);
        rnext    = wrap_inc(rptr);
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push_ok && (wptr == PW'(i))) mem[i] <= wdata;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            stat <= FST_EMPTY;
        end else begin
            if (push_ok) wptr <= wnext;
            if (pop_ok)  rptr <= rnext;
            unique case ({push_ok, pop_ok})
                2'b10:   stat <= (wnext == rptr) ? FST_FULL : FST_SOME;
                2'b01:   stat <= (rnext == wptr) ? FST_EMPTY : FST_SOME;
                default: stat <= stat;
            endcase
        end
    end

    // Oldest byte, or all ones when nothing is stored.
    always_comb head = is_empty ? '1 : mem[rptr];

endmodule

// File: rtl/ecpx_regs.sv
// Module: ecpx_regs
// Software-visible storage: mode field and spare control bits, configuration
// byte and the plain offset-0 byte used outside FIFO-test mode.
// Assumes wr_en is a qualified bus write; flags a mode change combinationally.
module ecpx_regs
    import ecpx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output mode_e             mode,
    output logic [2:0]        spare,
    output logic [DW-1:0]     cfg,
    output logic [DW-1:0]     plain,
    output logic              mode_change
);

    logic ctrl_wr;

    // Detect a control write that selects a different mode.
    always_comb begin
        ctrl_wr     = wr_en && (addr == OFS_CTRL);
        mode_change = ctrl_wr && (wdata[7:5] != mode);
    end

    // Register updates for the three writable locations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_COMPAT;
            spare <= '0;
            cfg   <= '0;
            plain <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_DATA: if (mode != MODE_FIFO_TEST) plain <= wdata;
                OFS_CFG:  cfg <= wdata;
                OFS_CTRL: begin
                    mode  <= mode_e'(wdata[7:5]);
                    spare <= wdata[4:2];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ecpx_window.sv
// Module: ecpx_window (top)
// Eight-byte extended control window: decodes bus accesses, routes offset 0
// to the FIFO in FIFO-test mode and to a plain byte otherwise, and builds
// the read data. Assumes one access per cycle; read data is combinational.
module ecpx_window
    import ecpx_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);

    mode_e         cur_mode;
    logic [2:0]    spare;
    logic [DW-1:0] cfg_q, plain_q, fifo_head;
    logic          mode_change;
    fifo_stat_e    fifo_stat;
    logic          acc_wr, acc_rd, in_test, at_data, do_push, do_pop;

    // Access decode and FIFO request qualification.
    always_comb begin
        acc_wr  = bus_sel && bus_wr;
        acc_rd  = bus_sel && bus_rd;
        in_test = (cur_mode == MODE_FIFO_TEST);
        at_data = (bus_addr == OFS_DATA);
        do_push = acc_wr && at_data && in_test;
        do_pop  = acc_rd && at_data && in_test;
    end

    ecpx_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (acc_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .mode       (cur_mode),
        .spare      (spare),
        .cfg        (cfg_q),
        .plain      (plain_q),
        .mode_change(mode_change)
    );

    ecpx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(mode_change),
        .push (do_push),
        .pop  (do_pop),
        .wdata(bus_wdata),
        .head (fifo_head),
        .stat (fifo_stat)
    );

    // Read data selection by offset.
    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = in_test ? fifo_head : plain_q;
            OFS_CFG:  bus_rdata = cfg_q;
            OFS_CTRL: bus_rdata = {cur_mode, spare, fifo_stat};
            default:  bus_rdata = '1;
        endcase
    end

endmodule

// File: rtl/ecpx_window_chk.sv
// Module: ecpx_window_chk
// Temporal checks on the window's FIFO occupancy code, bound to the top.
module ecpx_window_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [1:0] stat_i,
    input logic [2:0] mode_i
);

    logic data_wr, data_rd, ctrl_wr, in_test;
    always_comb begin
        data_wr = bus_sel && bus_wr && (bus_addr == 3'd0);
        data_rd = bus_sel && bus_rd && (bus_addr == 3'd0);
        ctrl_wr = bus_sel && bus_wr && (bus_addr == 3'd2);
        in_test = (mode_i == 3'b110);
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) !rst_n |=> stat_i == 2'b01);

    // R2
    no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_i != 2'b11);

    // R3
    plain_no_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_test && (data_wr || data_rd) && !ctrl_wr) |=> $stable(stat_i));

    // R6
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && stat_i == 2'b10 && data_wr && !data_rd) |=> stat_i == 2'b10);

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && stat_i == 2'b01 && data_rd && !data_wr) |=> stat_i == 2'b01);

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[7:5] != mode_i) |=> stat_i == 2'b01);

    // R9
    same_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[7:5] == mode_i) |=> $stable(stat_i));

endmodule

bind ecpx_window ecpx_window_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .stat_i   (fifo_stat),
    .mode_i   (cur_mode)
);

// File: tb/ecpx_window_test.sv
// Directed bench for ecpx_window: one task per scenario, each self-checking.
module ecpx_window_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    ecpx_window uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s got=0x%02h expected=0x%02h", req, got, exp);
        end
    endtask

    // Generic access: strobes set at falling edge, data sampled mid-low-phase.
    task automatic access(input bit wr, input bit rd, input logic [2:0] a,
                          input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #5 q = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] q;
        access(1'b1, 1'b0, a, d, q);
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] q;
        access(1'b0, 1'b1, a, 8'h00, q);
        check(req, q, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 3'd2, 8'h01);
        rd_chk("R1 cfg", 3'd1, 8'h00);
        rd_chk("R1 data", 3'd0, 8'h00);
    endtask

    task automatic t_ctrl_bits;
        wr(3'd2, 8'h1E);
        rd_chk("R2 status bits not writable", 3'd2, 8'h1D);
    endtask

    task automatic t_plain;
        wr(3'd2, 8'h40);
        rd_chk("R8 mode change to 010", 3'd2, 8'h41);
        wr(3'd0, 8'h5A);
        rd_chk("R3 plain readback", 3'd0, 8'h5A);
        rd_chk("R3 plain again", 3'd0, 8'h5A);
        rd_chk("R3 status untouched", 3'd2, 8'h41);
    endtask

    task automatic t_cfg;
        wr(3'd1, 8'hA5);
        rd_chk("R10 cfg", 3'd1, 8'hA5);
        wr(3'd3, 8'h12);
        for (int a = 3; a < 8; a++) rd_chk("R10 unused offset", 3'(a), 8'hFF);
        rd_chk("R10 cfg kept", 3'd1, 8'hA5);
        rd_chk("R10 ctrl kept", 3'd2, 8'h41);
    endtask

    task automatic t_fifo;
        wr(3'd2, 8'hC0);
        rd_chk("R8 enter test mode", 3'd2, 8'hC1);
        wr(3'd0, 8'h11);
        rd_chk("R4 some data", 3'd2, 8'hC0);
        wr(3'd0, 8'h22);
        rd_chk("R4 full", 3'd2, 8'hC2);
        wr(3'd0, 8'h33);
        rd_chk("R6 still full", 3'd2, 8'hC2);
        rd_chk("R5 pop first", 3'd0, 8'h11);
        rd_chk("R5 some data", 3'd2, 8'hC0);
        rd_chk("R6 pop second, no overwrite", 3'd0, 8'h22);
        rd_chk("R5 empty", 3'd2, 8'hC1);
        rd_chk("R7 pop empty", 3'd0, 8'hFF);
        rd_chk("R7 still empty", 3'd2, 8'hC1);
    endtask

    task automatic t_wrap;
        wr(3'd0, 8'hA1);
        rd_chk("R12 pop A1", 3'd0, 8'hA1);
        wr(3'd0, 8'hB2);
        wr(3'd0, 8'hC3);
        rd_chk("R12 full across wrap", 3'd2, 8'hC2);
        rd_chk("R12 order B2", 3'd0, 8'hB2);
        rd_chk("R12 order C3", 3'd0, 8'hC3);
        rd_chk("R12 empty", 3'd2, 8'hC1);
    endtask

    task automatic t_same_mode;
        wr(3'd0, 8'h44);
        wr(3'd2, 8'hDC);
        rd_chk("R9 same mode keeps code", 3'd2, 8'hDC);
        rd_chk("R9 contents kept", 3'd0, 8'h44);
        rd_chk("R9 empty after pop", 3'd2, 8'hDD);
        wr(3'd2, 8'hC0);
    endtask

    task automatic t_flush;
        wr(3'd0, 8'h55);
        wr(3'd0, 8'h66);
        rd_chk("R4 full before flush", 3'd2, 8'hC2);
        wr(3'd2, 8'h20);
        rd_chk("R8 flushed", 3'd2, 8'h21);
        wr(3'd2, 8'h00);
        rd_chk("R3 plain survives FIFO traffic", 3'd0, 8'h5A);
        wr(3'd2, 8'hC0);
        rd_chk("R8 flushed pop", 3'd0, 8'hFF);
    endtask

    task automatic t_both;
        logic [7:0] q;
        access(1'b1, 1'b1, 3'd0, 8'h77, q);
        check("R11 empty rw returns FF", q, 8'hFF);
        rd_chk("R11 push kept", 3'd2, 8'hC0);
        wr(3'd0, 8'h88);
        rd_chk("R11 full", 3'd2, 8'hC2);
        access(1'b1, 1'b1, 3'd0, 8'h99, q);
        check("R11 full rw returns oldest", q, 8'h77);
        rd_chk("R11 stays full", 3'd2, 8'hC2);
        rd_chk("R11 next 88", 3'd0, 8'h88);
        rd_chk("R11 next 99", 3'd0, 8'h99);
        rd_chk("R11 empty", 3'd2, 8'hC1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ctrl_bits();
        t_plain();
        t_cfg();
        t_fifo();
        t_wrap();
        t_same_mode();
        t_flush();
        t_both();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

endmodule